// File: doc/BRIEF.md
# AHB-Lite Burst Master Sequencer

This block is the address-phase engine of a single-master AHB-Lite bus. A client hands it one command at a time: start address, direction, transfer size and burst kind. The block then issues every beat of that burst on the bus, marking the opening beat NONSEQ and each later beat SEQ. It computes each beat address for incrementing bursts and for wrapping bursts aligned to a line, and it overlaps the address of the next beat with the data phase of the current one.

Write data is taken from the client when a write beat's address is accepted, and it is driven on the bus one cycle later. Read data and error responses go back to the client as single-cycle strobes. The client can pause a burst with BUSY cycles. It ends an open-length incrementing burst by dropping a continue flag. When the slave returns ERROR, the block cancels the rest of the burst.

Top module: `ahbl_burst_seq`

## Requirements
- R1: HTRANS uses 00 IDLE, 01 BUSY, 10 NONSEQ, 11 SEQ; the first beat of each command is NONSEQ and every later beat of it is SEQ.
- R2: HBURST carries the command's burst code (000 SINGLE, 001 INCR, 010 WRAP4, 011 INCR4, 100 WRAP8, 101 INCR8, 110 WRAP16, 111 INCR16); fixed kinds issue exactly 1, 4, 8 or 16 beats and then IDLE.
- R3: In an incrementing burst each beat address is the previous one plus 2^HSIZE bytes (HSIZE 0 byte, 1 halfword, 2 word, 3 doubleword).
- R4: In a wrapping burst the address advances by 2^HSIZE but stays inside the aligned block of beats × 2^HSIZE bytes holding the start address, wrapping to its base.
- R5: The address of beat N+1 is on the bus during the data phase of beat N; wr_take pulses in the cycle a write beat's address is accepted, and the wr_data sampled then is on HWDATA in the following cycle.
- R6: While HREADY is low (and no ERROR is signalled) HADDR, HTRANS, HWRITE, HSIZE and HBURST keep their values and no beat is issued.
- R7: When hold_req is high as a non-final beat is accepted, or during a BUSY cycle, the next cycle is BUSY with the pending beat address; the burst resumes with SEQ at that address.
- R8: In an INCR burst, incr_go sampled low at a beat's acceptance (or during a BUSY cycle) makes that beat the last; the bus then goes IDLE.
- R9: rd_valid pulses with rd_data equal to HRDATA in the cycle a read data phase ends with HREADY high and OKAY.
- R10: On the first ERROR cycle (HREADY low, HRESP high) the next cycle drives IDLE, no further beat of that burst is issued, and err_pulse pulses in the second ERROR cycle.
- R11: After reset HTRANS is IDLE, cmd_ready follows HREADY, and rd_valid and err_pulse are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command taken at this edge when cmd_valid is high |
| cmd_addr | input | AW | Start address |
| cmd_write | input | 1 | 1 write, 0 read |
| cmd_size | input | 3 | Transfer size code |
| cmd_burst | input | 3 | Burst kind code |
| incr_go | input | 1 | Continue an INCR burst past the beat being accepted |
| hold_req | input | 1 | Insert BUSY before the next beat |
| wr_data | input | DW | Write data for the beat being accepted |
| wr_take | output | 1 | wr_data is captured at this edge |
| rd_valid | output | 1 | Read beat completed |
| rd_data | output | DW | Read data of the completed beat |
| err_pulse | output | 1 | Beat ended with ERROR |
| haddr | output | AW | Bus address |
| htrans | output | 2 | Bus transfer type |
| hwrite | output | 1 | Bus direction |
| hsize | output | 3 | Bus transfer size |
| hburst | output | 3 | Bus burst kind |
| hwdata | output | DW | Bus write data |
| hrdata | input | DW | Bus read data |
| hready | input | 1 | Bus ready |
| hresp | input | 1 | Bus response, 1 = ERROR |

## Verification
The properties take for granted that the slave behaves like a legal AHB-Lite slave. HREADY goes low only while a data phase is pending. HRESP rises only as the first cycle of a two-cycle ERROR pair on a pending data phase. The client's start addresses are aligned to the transfer size. The bench slave draws wait states only when its own model holds a pending data phase. It issues ERROR as exactly one low-ready cycle followed by one high-ready cycle. It derives every start address from a size-aligned offset, so the stimulus never leaves these bounds.

// File: rtl/ahbl_seq_pkg.sv
package ahbl_seq_pkg;

    typedef enum logic [1:0] {
        TR_IDLE   = 2'b00,
        TR_BUSY   = 2'b01,
        TR_NONSEQ = 2'b10,
        TR_SEQ    = 2'b11
    } trans_e;

    typedef enum logic [2:0] {
        BU_SINGLE = 3'b000,
        BU_INCR   = 3'b001,
        BU_WRAP4  = 3'b010,
        BU_INCR4  = 3'b011,
        BU_WRAP8  = 3'b100,
        BU_INCR8  = 3'b101,
        BU_WRAP16 = 3'b110,
        BU_INCR16 = 3'b111
    } burst_e;

    // Beat count of a fixed burst; 0 marks the open-length kind.
    function automatic logic [4:0] burst_len(burst_e b);
        case (b)
            BU_SINGLE:           return 5'd1;
            BU_WRAP4, BU_INCR4:  return 5'd4;
            BU_WRAP8, BU_INCR8:  return 5'd8;
            BU_WRAP16, BU_INCR16: return 5'd16;
            default:             return 5'd0;
        endcase
    endfunction

    function automatic logic is_wrap(burst_e b);
        return (b == BU_WRAP4) || (b == BU_WRAP8) || (b == BU_WRAP16);
    endfunction

    function automatic logic is_open(burst_e b);
        return b == BU_INCR;
    endfunction

endpackage

// File: rtl/ahbl_seq_addr_gen.sv
module ahbl_seq_addr_gen
    import ahbl_seq_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic [AW-1:0] cur_addr,
    input  logic [2:0]    size,
    input  burst_e        burst,
    output logic [AW-1:0] nxt_addr
);
    logic [AW-1:0] step;
    logic [AW-1:0] span;
    logic [AW-1:0] mask;
    logic [AW-1:0] inc;

    always_comb begin
        step = AW'(1) << size;
        span = AW'(burst_len(burst)) << size;
        mask = span - AW'(1);
        inc  = cur_addr + step;
        if (is_wrap(burst))
            nxt_addr = (cur_addr & ~mask) | (inc & mask);
        else
            nxt_addr = inc;
    end
endmodule

// File: rtl/ahbl_seq_beat_ctr.sv
module ahbl_seq_beat_ctr #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    input  logic          dec,
    output logic          last
);
    logic [CW-1:0] left_q;

    always_ff @(posedge clk) begin
        if (rst)
            left_q <= '0;
        else if (load)
            left_q <= load_val;
        else if (dec)
            left_q <= left_q - CW'(1);
    end

    assign last = (left_q == '0);
endmodule

// File: rtl/ahbl_seq_dphase.sv
module ahbl_seq_dphase #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          hready,
    input  logic          hresp,
    input  logic          issue,
    input  logic          issue_write,
    input  logic [DW-1:0] wr_data,
    input  logic [DW-1:0] hrdata,
    output logic [DW-1:0] hwdata,
    output logic          dp_valid,
    output logic          rd_valid,
    output logic [DW-1:0] rd_data,
    output logic          err_pulse
);
    logic dp_write;

    always_ff @(posedge clk) begin
        if (rst) begin
            dp_valid <= 1'b0;
            dp_write <= 1'b0;
            hwdata   <= '0;
        end else if (hready) begin
            dp_valid <= issue;
            dp_write <= issue_write;
            if (issue && issue_write)
                hwdata <= wr_data;
        end
    end

    assign rd_valid  = dp_valid && !dp_write && hready && !hresp;
    assign rd_data   = hrdata;
    assign err_pulse = dp_valid && hready && hresp;
endmodule

// File: rtl/ahbl_burst_seq.sv
module ahbl_burst_seq
    import ahbl_seq_pkg::*;
#(
    parameter int AW        = 32,
    parameter int DW        = 32,
    parameter int MAX_BEATS = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cmd_valid,
    output logic          cmd_ready,
    input  logic [AW-1:0] cmd_addr,
    input  logic          cmd_write,
    input  logic [2:0]    cmd_size,
    input  logic [2:0]    cmd_burst,
    input  logic          incr_go,
    input  logic          hold_req,
    input  logic [DW-1:0] wr_data,
    output logic          wr_take,
    output logic          rd_valid,
    output logic [DW-1:0] rd_data,
    output logic          err_pulse,
    output logic [AW-1:0] haddr,
    output logic [1:0]    htrans,
    output logic          hwrite,
    output logic [2:0]    hsize,
    output logic [2:0]    hburst,
    output logic [DW-1:0] hwdata,
    input  logic [DW-1:0] hrdata,
    input  logic          hready,
    input  logic          hresp
);
    localparam int CW = $clog2(MAX_BEATS);

    typedef struct packed {
        logic [AW-1:0] addr;
        trans_e        trans;
        logic          write;
        logic [2:0]    size;
        burst_e        burst;
    } aphase_t;

    aphase_t       ap_q, ap_d;
    logic [AW-1:0] nxt_addr;
    logic          last;
    logic          dp_valid;
    logic          active, accept, open_len, more, cont, in_busy, start, abort;
    logic [4:0]    cmd_len;
    logic [CW-1:0] load_val;

    assign active   = ap_q.trans[1];
    assign accept   = hready && active;
    assign open_len = is_open(ap_q.burst);
    assign more     = open_len ? incr_go : !last;
    assign cont     = accept && more;
    assign in_busy  = (ap_q.trans == TR_BUSY);
    assign cmd_ready = hready && ((ap_q.trans == TR_IDLE) || (accept && !more));
    assign start    = cmd_ready && cmd_valid;
    assign abort    = !hready && hresp && dp_valid;

    assign cmd_len  = burst_len(burst_e'(cmd_burst));
    assign load_val = (cmd_len == 5'd0) ? '0 : CW'(cmd_len - 5'd1);

    ahbl_seq_addr_gen #(.AW(AW)) addr_gen_i (
        .cur_addr (ap_q.addr),
        .size     (ap_q.size),
        .burst    (ap_q.burst),
        .nxt_addr (nxt_addr)
    );

    ahbl_seq_beat_ctr #(.CW(CW)) beat_ctr_i (
        .clk      (clk),
        .rst      (rst),
        .load     (start),
        .load_val (load_val),
        .dec      (cont && !open_len),
        .last     (last)
    );

    always_comb begin
        ap_d = ap_q;
        if (abort) begin
            ap_d.trans = TR_IDLE;
        end else if (hready) begin
            if (cont) begin
                ap_d.addr  = nxt_addr;
                ap_d.trans = hold_req ? TR_BUSY : TR_SEQ;
            end else if (in_busy) begin
                if (open_len && !incr_go)
                    ap_d.trans = TR_IDLE;
                else
                    ap_d.trans = hold_req ? TR_BUSY : TR_SEQ;
            end else if (start) begin
                ap_d.addr  = cmd_addr;
                ap_d.trans = TR_NONSEQ;
                ap_d.write = cmd_write;
                ap_d.size  = cmd_size;
                ap_d.burst = burst_e'(cmd_burst);
            end else begin
                ap_d.trans = TR_IDLE;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ap_q.addr  <= '0;
            ap_q.trans <= TR_IDLE;
            ap_q.write <= 1'b0;
            ap_q.size  <= 3'd0;
            ap_q.burst <= BU_SINGLE;
        end else begin
            ap_q <= ap_d;
        end
    end

    ahbl_seq_dphase #(.DW(DW)) dphase_i (
        .clk         (clk),
        .rst         (rst),
        .hready      (hready),
        .hresp       (hresp),
        .issue       (accept),
        .issue_write (ap_q.write),
        .wr_data     (wr_data),
        .hrdata      (hrdata),
        .hwdata      (hwdata),
        .dp_valid    (dp_valid),
        .rd_valid    (rd_valid),
        .rd_data     (rd_data),
        .err_pulse   (err_pulse)
    );

    assign wr_take = accept && ap_q.write;
    assign haddr   = ap_q.addr;
    assign htrans  = ap_q.trans;
    assign hwrite  = ap_q.write;
    assign hsize   = ap_q.size;
    assign hburst  = ap_q.burst;
endmodule

// File: rtl/ahbl_burst_seq_chk.sv
module ahbl_burst_seq_chk #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst,
    input logic          hready,
    input logic          hresp,
    input logic [AW-1:0] haddr,
    input logic [1:0]    htrans,
    input logic          hwrite,
    input logic [2:0]    hsize,
    input logic [2:0]    hburst
);
    // R1: SEQ never directly follows IDLE
    a_r1_seq_after_beat: assert property (@(posedge clk) disable iff (rst)
        (htrans == 2'b11) |-> ($past(htrans) != 2'b00));

    // R7: BUSY only inside a burst
    a_r7_busy_in_burst: assert property (@(posedge clk) disable iff (rst)
        (htrans == 2'b01) |-> ($past(htrans) != 2'b00));

    // R7: address is kept across a BUSY cycle
    a_r7_busy_keeps_addr: assert property (@(posedge clk) disable iff (rst)
        (htrans == 2'b01) |=> (haddr == $past(haddr)));

    // R6: address phase frozen during a wait state
    a_r6_hold_on_wait: assert property (@(posedge clk) disable iff (rst)
        (!hready && !hresp) |=> ($stable(haddr) && $stable(htrans) &&
                                 $stable(hwrite) && $stable(hsize) && $stable(hburst)));

    // R3: incrementing burst steps by the transfer size
    a_r3_incr_step: assert property (@(posedge clk) disable iff (rst)
        (hready && htrans[1] && hburst[0] && !hresp) |=>
            ((htrans != 2'b11) || (haddr == $past(haddr) + (AW'(1) << $past(hsize)))));

    // R10: first ERROR cycle is followed by IDLE
    a_r10_abort_idle: assert property (@(posedge clk) disable iff (rst)
        (!hready && hresp) |=> (htrans == 2'b00));
endmodule

bind ahbl_burst_seq ahbl_burst_seq_chk #(.AW(AW)) chk_i (
    .clk    (clk),
    .rst    (rst),
    .hready (hready),
    .hresp  (hresp),
    .haddr  (haddr),
    .htrans (htrans),
    .hwrite (hwrite),
    .hsize  (hsize),
    .hburst (hburst)
);

// File: tb/ahbl_burst_seq_tb_top.sv
`timescale 1ns/1ps
module ahbl_burst_seq_tb_top;
    import ahbl_seq_pkg::*;

    localparam int AW = 32;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cmd_valid = 1'b0;
    logic          cmd_ready;
    logic [AW-1:0] cmd_addr = '0;
    logic          cmd_write = 1'b0;
    logic [2:0]    cmd_size = 3'd0;
    logic [2:0]    cmd_burst = 3'd0;
    logic          incr_go = 1'b0;
    logic          hold_req = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic          wr_take;
    logic          rd_valid;
    logic [DW-1:0] rd_data;
    logic          err_pulse;
    logic [AW-1:0] haddr;
    logic [1:0]    htrans;
    logic          hwrite;
    logic [2:0]    hsize;
    logic [2:0]    hburst;
    logic [DW-1:0] hwdata;
    logic [DW-1:0] hrdata = '0;
    logic          hready = 1'b1;
    logic          hresp = 1'b0;

    always #10 clk = ~clk;

    ahbl_burst_seq #(.AW(AW), .DW(DW)) dut_i (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_addr(cmd_addr), .cmd_write(cmd_write), .cmd_size(cmd_size),
        .cmd_burst(cmd_burst), .incr_go(incr_go), .hold_req(hold_req),
        .wr_data(wr_data), .wr_take(wr_take), .rd_valid(rd_valid),
        .rd_data(rd_data), .err_pulse(err_pulse), .haddr(haddr),
        .htrans(htrans), .hwrite(hwrite), .hsize(hsize), .hburst(hburst),
        .hwdata(hwdata), .hrdata(hrdata), .hready(hready), .hresp(hresp)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    // bench model of the running command
    logic [AW-1:0] cur_start;
    int            cur_size, cur_burst, cur_write;
    int            exp_len = 0, issued = 0;
    int            busy_k = -1, busy_rem = 0, busy_seen = 0;
    int            err_at = -1, err_phase = 0, err_seen = 0;
    bit            dp_pending = 1'b0, dp_write = 1'b0;
    logic [AW-1:0] dp_addr;
    int            dp_idx;
    logic [15:0]   lfsr = 16'hACE1;
    bit            snap_valid = 1'b0;
    logic [AW+10:0] snap;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic int fixed_len(int b);
        case (b)
            0: return 1;
            2, 3: return 4;
            4, 5: return 8;
            6, 7: return 16;
            default: return 0;
        endcase
    endfunction

    function automatic logic [AW-1:0] exp_addr(logic [AW-1:0] st, int sz_code, int b, int i);
        int unsigned sz, span, off, base;
        sz = 1 << sz_code;
        if (b == 2 || b == 4 || b == 6) begin
            span = fixed_len(b) * sz;
            base = int'(st) - (int'(st) % span);
            off  = (int'(st) - base + i * sz) % span;
            return AW'(base + off);
        end
        return st + AW'(i * sz);
    endfunction

    function automatic logic [DW-1:0] rdf(logic [AW-1:0] a);
        return (a * 32'h0000_9E37) ^ 32'h5A5A_0000;
    endfunction

    function automatic logic [DW-1:0] wdf(logic [AW-1:0] st, int i);
        return 32'hC0DE_0000 ^ (st << 4) ^ DW'(i);
    endfunction

    // slave model and monitor
    initial begin
        forever begin
            @(negedge clk);
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            if (rst) begin
                hready = 1'b1; hresp = 1'b0;
            end else if (dp_pending && err_at == dp_idx && err_phase == 0) begin
                hready = 1'b0; hresp = 1'b1; err_phase = 1;
            end else if (err_phase == 1) begin
                hready = 1'b1; hresp = 1'b1; err_phase = 2;
            end else begin
                hresp  = 1'b0;
                hready = !(dp_pending && lfsr[1:0] == 2'b00);
            end
            hrdata  = (dp_pending && !dp_write) ? rdf(dp_addr) : '0;
            incr_go = (issued + 1 < exp_len);
            wr_data = wdf(cur_start, issued);
            if (htrans == TR_BUSY)
                hold_req = (busy_rem > 1);
            else
                hold_req = htrans[1] && (issued == busy_k);
            #1;
            if (!rst) begin
                if (snap_valid) begin
                    chk({haddr, htrans, hwrite, hsize, hburst} == snap, "R6",
                        "address phase changed in wait", 64'({haddr, htrans}), 64'(snap[AW+10:9]));
                    snap_valid = 1'b0;
                end
                if (hready && dp_pending) begin
                    if (hresp) begin
                        chk(err_pulse == 1'b1, "R10", "err_pulse", 64'(err_pulse), 64'd1);
                        chk(rd_valid == 1'b0, "R10", "rd_valid on error", 64'(rd_valid), 64'd0);
                        err_seen++;
                    end else if (dp_write) begin
                        chk(hwdata == wdf(cur_start, dp_idx), "R5", "hwdata", 64'(hwdata),
                            64'(wdf(cur_start, dp_idx)));
                        chk(rd_valid == 1'b0, "R9", "rd_valid on write", 64'(rd_valid), 64'd0);
                    end else begin
                        chk(rd_valid == 1'b1 && rd_data == rdf(dp_addr), "R9", "read return",
                            64'({rd_valid, rd_data}), 64'({1'b1, rdf(dp_addr)}));
                    end
                    if (!hresp && err_at < 0 && dp_idx + 1 < exp_len)
                        chk(htrans == TR_SEQ || htrans == TR_BUSY, "R5",
                            "next beat not overlapped", 64'(htrans), 64'(TR_SEQ));
                    dp_pending = 1'b0;
                end
                if (hready && htrans[1]) begin
                    chk(htrans == ((issued == 0) ? TR_NONSEQ : TR_SEQ), "R1", "htrans of beat",
                        64'(htrans), 64'((issued == 0) ? TR_NONSEQ : TR_SEQ));
                    chk(haddr == exp_addr(cur_start, cur_size, cur_burst, issued),
                        (cur_burst == 2 || cur_burst == 4 || cur_burst == 6) ? "R4" : "R3",
                        "beat address", 64'(haddr),
                        64'(exp_addr(cur_start, cur_size, cur_burst, issued)));
                    chk(hburst == 3'(cur_burst) && hsize == 3'(cur_size) && hwrite == cur_write[0],
                        "R2", "burst/size/dir", 64'({hburst, hsize, hwrite}),
                        64'({3'(cur_burst), 3'(cur_size), cur_write[0]}));
                    chk(wr_take == cur_write[0], "R5", "wr_take", 64'(wr_take), 64'(cur_write));
                    if (issued == busy_k) busy_rem = 2;
                    dp_pending = 1'b1; dp_addr = haddr; dp_idx = issued; dp_write = hwrite;
                    issued++;
                end else if (hready && htrans == TR_BUSY) begin
                    chk(haddr == exp_addr(cur_start, cur_size, cur_burst, issued), "R7",
                        "BUSY address", 64'(haddr),
                        64'(exp_addr(cur_start, cur_size, cur_burst, issued)));
                    busy_seen++;
                    busy_rem--;
                end
                if (!hready && !hresp) begin
                    snap = {haddr, htrans, hwrite, hsize, hburst};
                    snap_valid = 1'b1;
                end
            end
        end
    end

    task automatic run(input logic [AW-1:0] a, input int w, input int s, input int b,
                       input int ilen, input int bk, input int ek);
        int n, want;
        @(negedge clk); #2;
        cur_start = a; cur_size = s; cur_burst = b; cur_write = w;
        exp_len = (b == 1) ? ilen : fixed_len(b);
        issued = 0; busy_k = bk; busy_rem = 0; busy_seen = 0;
        err_at = ek; err_phase = 0; err_seen = 0;
        cmd_addr = a; cmd_write = w[0]; cmd_size = 3'(s); cmd_burst = 3'(b);
        cmd_valid = 1'b1;
        #1;
        while (!cmd_ready) begin @(negedge clk); #3; end
        @(posedge clk); #1;
        cmd_valid = 1'b0;
        n = 0;
        while (n < 400 && !(((issued == exp_len) || (ek >= 0 && err_phase == 2)) && !dp_pending)) begin
            @(negedge clk); #3; n++;
        end
        @(negedge clk); #3;
        want = (ek >= 0) ? ek + 1 : exp_len;
        chk(htrans == TR_IDLE, (b == 1) ? "R8" : "R2", "bus not IDLE after burst",
            64'(htrans), 64'(TR_IDLE));
        chk(issued == want, (ek >= 0) ? "R10" : ((b == 1) ? "R8" : "R2"), "beat count",
            64'(issued), 64'(want));
        if (bk >= 0 && bk + 1 < exp_len && ek < 0)
            chk(busy_seen == 2, "R7", "BUSY cycles", 64'(busy_seen), 64'd2);
        if (ek >= 0)
            chk(err_seen == 1, "R10", "error strobes", 64'(err_seen), 64'd1);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); #2;
        rst = 1'b0;
        @(negedge clk); #3;
        chk(htrans == TR_IDLE, "R11", "reset htrans", 64'(htrans), 64'(TR_IDLE));
        chk(cmd_ready == 1'b1 && rd_valid == 1'b0 && err_pulse == 1'b0, "R11",
            "reset strobes", 64'({cmd_ready, rd_valid, err_pulse}), 64'b100);
        begin
            int k;
            k = 0;
            for (int b = 0; b < 8; b++) begin
                for (int s = 0; s < 3; s++) begin
                    for (int w = 0; w < 2; w++) begin
                        run(32'h0000_4000 + AW'(((k * 5) % 16) << s), w, s, b,
                            1 + (k % 6), (k % 3 == 1) ? 1 : -1, -1);
                        k++;
                    end
                end
            end
        end
        run(32'h0000_8010, 0, 2, 5, 0, -1, 2);
        run(32'h0000_8104, 1, 2, 2, 0, -1, 0);
        run(32'h0000_8200, 0, 1, 1, 6, -1, 1);
        run(32'h0000_8300, 1, 0, 3, 0, 0, -1);
        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule